// File: doc/BRIEF.md
# Off-Chip Load Predictor with Speculative Memory Issue

For every load, this block decides whether the data is likely to miss the entire on-chip cache hierarchy. The decision comes from a small perceptron. Three program features each select one learned signed weight from a table of their own, and the three weights are summed and compared against an activation threshold. When the sum reaches the threshold and the load's physical address is known, the block starts a speculative line read toward the memory controller. The normal cache lookup for that load goes ahead in parallel.

Each load is tracked by its identifier from issue until it resolves. At resolution the block learns whether the load really left the chip. It then nudges the weights it used toward the true outcome, but only when the guess was wrong or not confident enough.

Speculative reads still in flight are recorded by line address. If a later demand miss asks for one of those lines, it is told to merge with the running read rather than start a new one.

Top module: `offchip_predictor`

## Requirements
- R1: After reset, `pred_valid` and `spec_valid` are low, every weight is 0, the threshold is 0, the load-PC history holds zeros and no line is pending, so a demand miss gets `miss_fetch`=1 and `miss_merge`=0.
- R2: The program counter is folded to a 6-bit value F(pc) = pc[7:2] XOR pc[13:8]. The three feature indices are: F(pc); the history hash of R4; and F(pc) XOR paddr[5:0] (the byte offset within a 64-byte line). Each feature owns a 64-entry table of 5-bit two's-complement weights.
- R3: One cycle after `adr_valid`, `pred_valid` is high with `pred_id` = `adr_id`. `pred_offchip` is 1 exactly when the signed sum of the three selected weights is greater than or equal to the current threshold.
- R4: The history index of a load is the XOR over k = 0..3 of F(h_k) rotated left by k within 6 bits. Here h_0 is the most recent earlier load PC, presented on `ld_valid` before this load, and h_3 is the oldest of the four.
- R5: On a resolution, the three weights recorded for that load are trained only if the recorded decision differs from `res_offchip` or the absolute value of the recorded sum is below 4. Training adds +1 toward off-chip or −1 toward on-chip, saturating at +15 and −16.
- R6: Per-load state is kept in a table indexed by the 4-bit load identifier. A resolution for an identifier with no predicted load changes no weight.
- R7: A speculative request for line paddr[39:6] is started only for a load predicted off-chip, and `spec_valid` rises one cycle after `adr_valid`. No request is started if the output register is occupied and not being accepted, or if that line is already pending.
- R8: While `spec_valid` is high and `spec_ready` is low, `spec_valid` stays high and `spec_line` stays unchanged. The request drops in the cycle after `spec_ready` is high.
- R9: At most 8 lines are pending. A line enters the table when its request starts and leaves it when `cmp_valid` reports that line. With 8 lines pending, no new request starts.
- R10: In the same cycle as `miss_valid`, `miss_merge` is 1 and `miss_fetch` is 0 when `miss_line` is pending. Otherwise `miss_fetch` is 1 and `miss_merge` is 0.
- R11: A value written with `thr_we` is used as the threshold from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | 7 | Signed threshold value |
| ld_valid | input | 1 | Load issued |
| ld_id | input | 4 | Load identifier at issue |
| ld_pc | input | 32 | Load program counter |
| adr_valid | input | 1 | Physical address ready |
| adr_id | input | 4 | Load identifier for the address |
| adr_paddr | input | 40 | Physical address |
| res_valid | input | 1 | Load resolved |
| res_id | input | 4 | Identifier of the resolved load |
| res_offchip | input | 1 | 1 if the load went off-chip |
| pred_valid | output | 1 | Prediction valid |
| pred_id | output | 4 | Identifier of the predicted load |
| pred_offchip | output | 1 | Predicted off-chip |
| spec_valid | output | 1 | Speculative read request valid |
| spec_ready | input | 1 | Memory side accepts the request |
| spec_line | output | 34 | Line address of the speculative read |
| cmp_valid | input | 1 | A speculative read completed |
| cmp_line | input | 34 | Line address of the completed read |
| miss_valid | input | 1 | Demand miss from the last cache level |
| miss_line | input | 34 | Line address of the demand miss |
| miss_merge | output | 1 | Miss joins a pending speculative read |
| miss_fetch | output | 1 | Miss needs its own memory request |

## Verification
The bench draws loads from a small set of program counters. Each counter's outcome is mostly fixed, with some noise, so the weights climb to saturation. Long runs of one outcome therefore separate a correct clamp from a wrapping one, and the noisy outcomes exercise the confidence margin.

Two loads are interleaved in reverse order, so predictions show whether per-identifier state, rather than the newest load's, is used. The second address also shows that an occupied request register drops the request. Physical lines come from a pool larger than the pending table, which fills the table, repeats lines already in flight and gives demand misses that both hit and miss. Threshold changes, including one above the largest reachable sum, show the comparison and its timing. Stray resolutions on idle identifiers show that training is ignored there.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  parameter int PC_W  = 32;
  parameter int PA_W  = 40;
  parameter int IDX_W = 6;
  parameter int OFF_W = 6;
  parameter int WGT_W = 5;
  parameter int NFEAT = 3;
  localparam int SUM_W  = WGT_W + 2;
  localparam int LINE_W = PA_W - OFF_W;

  typedef logic [IDX_W-1:0]              idx_t;
  typedef logic signed [WGT_W-1:0]       wgt_t;
  typedef logic signed [SUM_W-1:0]       sum_t;
  typedef logic [LINE_W-1:0]             line_t;
  typedef logic [PC_W-1:0]               pc_t;
  typedef logic [NFEAT-1:0][IDX_W-1:0]   idxv_t;
  typedef logic [NFEAT-1:0][WGT_W-1:0]   wgtv_t;

  // per-load record: predicted flag, feature indices, sum and decision
  typedef struct packed {
    logic  done;
    idxv_t idx;
    sum_t  sum;
    logic  dec;
  } trk_t;

  // fold a program counter into one table index
  function automatic idx_t fold_pc(input pc_t pc);
    return pc[2 +: IDX_W] ^ pc[2 + IDX_W +: IDX_W];
  endfunction

  function automatic idx_t rotl(input idx_t x, input int k);
    idx_t r;
    r = x;
    for (int i = 0; i < k; i++) r = {r[IDX_W-2:0], r[IDX_W-1]};
    return r;
  endfunction

  function automatic idx_t off_idx(input idx_t pcf, input logic [OFF_W-1:0] off);
    return pcf ^ idx_t'(off);
  endfunction

  // signed sum of all selected weights
  function automatic sum_t perc_sum(input wgtv_t w);
    sum_t s;
    s = '0;
    for (int f = 0; f < NFEAT; f++)
      s = s + {{(SUM_W-WGT_W){w[f][WGT_W-1]}}, w[f]};
    return s;
  endfunction

  // one saturating training step
  function automatic wgt_t sat_step(input wgt_t w, input logic up);
    wgt_t hi;
    wgt_t lo;
    hi = {1'b0, {(WGT_W-1){1'b1}}};
    lo = {1'b1, {(WGT_W-1){1'b0}}};
    if (up) return (w == hi) ? w : w + wgt_t'(1);
    else    return (w == lo) ? w : w - wgt_t'(1);
  endfunction

  // train on a wrong guess or a low-confidence sum
  function automatic logic want_train(input logic dec, input logic outcome,
                                      input sum_t s, input int margin);
    int v;
    v = int'(s);
    if (v < 0) v = -v;
    return (dec != outcome) || (v < margin);
  endfunction
endpackage

// File: rtl/ocp_hist.sv
module ocp_hist
  import ocp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  idx_t pcf_in,
  output idx_t hash
);
  idx_t hq [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) hq[k] <= '0;
    end else if (push) begin
      hq[0] <= pcf_in;
      for (int k = 1; k < DEPTH; k++) hq[k] <= hq[k-1];
    end
  end

  // older entries are rotated further before combining
  always_comb begin
    hash = '0;
    for (int k = 0; k < DEPTH; k++) hash = hash ^ rotl(hq[k], k % IDX_W);
  end
endmodule

// File: rtl/ocp_weights.sv
module ocp_weights
  import ocp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  idxv_t rd_idx,
  output wgtv_t rd_w,
  input  logic  trn_en,
  input  logic  trn_up,
  input  idxv_t trn_idx
);
  localparam int ENTRIES = 2 ** IDX_W;

  genvar f;
  generate
    for (f = 0; f < NFEAT; f++) begin : g_tbl
      wgt_t tbl [ENTRIES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
        end else if (trn_en) begin
          tbl[trn_idx[f]] <= sat_step(tbl[trn_idx[f]], trn_up);
        end
      end

      assign rd_w[f] = tbl[rd_idx[f]];
    end
  endgenerate
endmodule

// File: rtl/ocp_track.sv
module ocp_track
  import ocp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_en,
  input  logic [ID_W-1:0] iss_id,
  input  idx_t            iss_pcf,
  input  idx_t            iss_hist,
  input  logic            prd_en,
  input  logic [ID_W-1:0] prd_id,
  input  idx_t            prd_off,
  input  sum_t            prd_sum,
  input  logic            prd_dec,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] a_id,
  output idx_t            a_pcf,
  output idx_t            a_hist,
  input  logic [ID_W-1:0] r_id,
  output trk_t            r_ent
);
  localparam int N = 2 ** ID_W;

  trk_t ent [N];

  // later writes in this block take precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;
    end else begin
      if (clr_en) ent[clr_id] <= '0;
      if (prd_en) begin
        ent[prd_id].done   <= 1'b1;
        ent[prd_id].idx[2] <= prd_off;
        ent[prd_id].sum    <= prd_sum;
        ent[prd_id].dec    <= prd_dec;
      end
      if (iss_en) begin
        ent[iss_id].done <= 1'b0;
        ent[iss_id].idx  <= {{IDX_W{1'b0}}, iss_hist, iss_pcf};
        ent[iss_id].sum  <= '0;
        ent[iss_id].dec  <= 1'b0;
      end
    end
  end

  assign a_pcf  = ent[a_id].idx[0];
  assign a_hist = ent[a_id].idx[1];
  assign r_ent  = ent[r_id];
endmodule

// File: rtl/ocp_pend.sv
module ocp_pend
  import ocp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  line_t            alloc_line,
  input  logic             free_en,
  input  line_t            free_line,
  input  line_t            look_a,
  output logic             hit_a,
  input  line_t            look_m,
  output logic             hit_m,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [DEPTH-1:0] pv;
  line_t            pl [DEPTH];
  logic [DEPTH-1:0] pick;

  // lowest free slot, one-hot
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!pv[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    hit_a = 1'b0;
    hit_m = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pv[i] && pl[i] == look_a) hit_a = 1'b1;
      if (pv[i] && pl[i] == look_m) hit_m = 1'b1;
    end
  end

  assign full  = &pv;
  assign count = CNT_W'($countones(pv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < DEPTH; i++) pl[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_en && pv[i] && pl[i] == free_line) pv[i] <= 1'b0;
        if (alloc_en && pick[i]) begin
          pv[i] <= 1'b1;
          pl[i] <= alloc_line;
        end
      end
    end
  end
endmodule

// File: rtl/offchip_predictor.sv
module offchip_predictor
  import ocp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int PEND_N = 8,
  parameter int HIST_N = 4,
  parameter int MARGIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic signed [SUM_W-1:0] thr_val,
  input  logic              ld_valid,
  input  logic [ID_W-1:0]   ld_id,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic              adr_valid,
  input  logic [ID_W-1:0]   adr_id,
  input  logic [PA_W-1:0]   adr_paddr,
  input  logic              res_valid,
  input  logic [ID_W-1:0]   res_id,
  input  logic              res_offchip,
  output logic              pred_valid,
  output logic [ID_W-1:0]   pred_id,
  output logic              pred_offchip,
  output logic              spec_valid,
  input  logic              spec_ready,
  output logic [LINE_W-1:0] spec_line,
  input  logic              cmp_valid,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  output logic              miss_merge,
  output logic              miss_fetch
);
  localparam int CNT_W = $clog2(PEND_N + 1);

  // named internal events
  idx_t             ld_pcf;
  idx_t             hist_hash;
  idx_t             a_pcf;
  idx_t             a_hist;
  idx_t             a_off;
  idxv_t            rd_idx;
  wgtv_t            rd_w;
  sum_t             sum_now;
  logic             decide;
  trk_t             r_ent;
  logic             train_fire;
  line_t            adr_line;
  logic             pend_hit_adr;
  logic             pend_hit_miss;
  logic             pend_full;
  logic [CNT_W-1:0] pend_cnt;
  logic             hold_free;
  logic             spec_load;

  sum_t             thr_q;
  logic             spec_valid_q;
  line_t            spec_line_q;

  assign ld_pcf = fold_pc(ld_pc);

  ocp_hist #(.DEPTH(HIST_N)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (ld_valid),
    .pcf_in (ld_pcf),
    .hash   (hist_hash)
  );

  ocp_track #(.ID_W(ID_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_en   (ld_valid),
    .iss_id   (ld_id),
    .iss_pcf  (ld_pcf),
    .iss_hist (hist_hash),
    .prd_en   (adr_valid),
    .prd_id   (adr_id),
    .prd_off  (a_off),
    .prd_sum  (sum_now),
    .prd_dec  (decide),
    .clr_en   (res_valid),
    .clr_id   (res_id),
    .a_id     (adr_id),
    .a_pcf    (a_pcf),
    .a_hist   (a_hist),
    .r_id     (res_id),
    .r_ent    (r_ent)
  );

  assign a_off   = off_idx(a_pcf, adr_paddr[OFF_W-1:0]);
  assign rd_idx  = {a_off, a_hist, a_pcf};
  assign sum_now = perc_sum(rd_w);
  assign decide  = (sum_now >= thr_q);

  assign train_fire = res_valid && r_ent.done &&
                      want_train(r_ent.dec, res_offchip, r_ent.sum, MARGIN);

  ocp_weights u_weights (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_w    (rd_w),
    .trn_en  (train_fire),
    .trn_up  (res_offchip),
    .trn_idx (r_ent.idx)
  );

  assign adr_line  = adr_paddr[PA_W-1:OFF_W];
  assign hold_free = !spec_valid_q || spec_ready;
  assign spec_load = adr_valid && decide && hold_free && !pend_hit_adr && !pend_full;

  ocp_pend #(.DEPTH(PEND_N), .CNT_W(CNT_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (spec_load),
    .alloc_line (adr_line),
    .free_en    (cmp_valid),
    .free_line  (cmp_line),
    .look_a     (adr_line),
    .hit_a      (pend_hit_adr),
    .look_m     (miss_line),
    .hit_m      (pend_hit_miss),
    .full       (pend_full),
    .count      (pend_cnt)
  );

  assign miss_merge = miss_valid && pend_hit_miss;
  assign miss_fetch = miss_valid && !pend_hit_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q        <= '0;
      spec_valid_q <= 1'b0;
      spec_line_q  <= '0;
      pred_valid   <= 1'b0;
      pred_id      <= '0;
      pred_offchip <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_val;
      if (spec_load) begin
        spec_valid_q <= 1'b1;
        spec_line_q  <= adr_line;
      end else if (spec_ready) begin
        spec_valid_q <= 1'b0;
      end
      pred_valid <= adr_valid;
      if (adr_valid) begin
        pred_id      <= adr_id;
        pred_offchip <= decide;
      end
    end
  end

  assign spec_valid = spec_valid_q;
  assign spec_line  = spec_line_q;
endmodule

// File: rtl/offchip_predictor_chk.sv
module offchip_predictor_chk
  import ocp_pkg::*;
#(
  parameter int PEND_N = 8,
  parameter int CNT_W  = $clog2(PEND_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adr_valid,
  input logic             pred_valid,
  input logic             pred_offchip,
  input logic             spec_valid,
  input logic             spec_ready,
  input line_t            spec_line,
  input logic             miss_merge,
  input logic             pend_hit_adr,
  input logic [CNT_W-1:0] pend_cnt
);
  AST_PRED_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(adr_valid)); // R3

  AST_SPEC_ONLY_PREDICTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_valid) |-> pred_valid && pred_offchip); // R7

  AST_SPEC_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_valid) |-> !$past(pend_hit_adr)); // R7

  AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spec_valid && !spec_ready |=> spec_valid && $stable(spec_line)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_valid) |-> $past(pend_cnt) < CNT_W'(PEND_N)); // R9

  AST_MERGE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    miss_merge |-> pend_cnt != '0); // R10
endmodule

bind offchip_predictor offchip_predictor_chk #(.PEND_N(PEND_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adr_valid    (adr_valid),
  .pred_valid   (pred_valid),
  .pred_offchip (pred_offchip),
  .spec_valid   (spec_valid),
  .spec_ready   (spec_ready),
  .spec_line    (spec_line),
  .miss_merge   (miss_merge),
  .pend_hit_adr (pend_hit_adr),
  .pend_cnt     (pend_cnt)
);

// File: tb/offchip_predictor_bench.sv
module offchip_predictor_bench;
  import ocp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic thr_we;
  logic signed [SUM_W-1:0] thr_val;
  logic ld_valid, adr_valid, res_valid, res_offchip;
  logic [3:0] ld_id, adr_id, res_id, pred_id;
  logic [PC_W-1:0] ld_pc;
  logic [PA_W-1:0] adr_paddr;
  logic pred_valid, pred_offchip, spec_valid, spec_ready, cmp_valid, miss_valid;
  logic miss_merge, miss_fetch;
  logic [LINE_W-1:0] spec_line, cmp_line, miss_line;

  offchip_predictor u_offchip_predictor (.*);

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int w [3][64];
  int hist [4];
  int thr;
  int t_i0 [16], t_i1 [16], t_i2 [16], t_sum [16];
  bit t_dec [16], t_done [16];
  bit mpv [8];
  logic [LINE_W-1:0] mpl [8];
  bit m_hold;
  logic [LINE_W-1:0] m_line;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_fold(input logic [31:0] pc);
    return int'(((pc >> 2) ^ (pc >> 8)) & 32'h3f);
  endfunction
  function automatic int m_rot(input int x, input int k);
    return ((x << k) | (x >> (6 - k))) & 63;
  endfunction
  function automatic int m_hash();
    int h = 0;
    for (int k = 0; k < 4; k++) h ^= m_rot(hist[k], k);
    return h;
  endfunction
  function automatic bit m_has(input logic [LINE_W-1:0] l);
    for (int i = 0; i < 8; i++) if (mpv[i] && mpl[i] == l) return 1'b1;
    return 1'b0;
  endfunction
  function automatic int m_cnt();
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(mpv[i]);
    return c;
  endfunction
  function automatic logic [31:0] pc_of(input int k);
    return 32'h0040_1000 + 32'(k) * 32'h0000_0134;
  endfunction

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_val = SUM_W'(v);
    @(negedge clk);
    thr_we = 1'b0;
    thr = v;
  endtask

  task automatic do_load(input int id, input logic [31:0] pc);
    @(negedge clk);
    ld_valid = 1'b1; ld_id = 4'(id); ld_pc = pc;
    t_i0[id] = m_fold(pc);
    t_i1[id] = m_hash();
    t_done[id] = 1'b0;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = m_fold(pc);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_addr(input int id, input logic [LINE_W-1:0] line, input string tag);
    logic [5:0] off;
    int s;
    bit d, ld;
    off = 6'($urandom);
    @(negedge clk);
    adr_valid = 1'b1; adr_id = 4'(id); adr_paddr = {line, off};
    t_i2[id] = t_i0[id] ^ int'(off);
    s = w[0][t_i0[id]] + w[1][t_i1[id]] + w[2][t_i2[id]];
    d = (s >= thr);
    t_sum[id] = s; t_dec[id] = d; t_done[id] = 1'b1;
    ld = d && !m_hold && !m_has(line) && m_cnt() < 8;
    @(negedge clk);
    adr_valid = 1'b0;
    chk("R3 pred_valid", 64'(pred_valid), 64'd1);
    chk("R3 pred_id", 64'(pred_id), 64'(id));
    chk({tag, " pred_offchip"}, 64'(pred_offchip), 64'(d));
    if (d && !m_has(line) && !m_hold && m_cnt() == 8)
      chk("R9 full blocks request", 64'(spec_valid), 64'd0);
    else
      chk("R7 spec_valid", 64'(spec_valid), 64'(m_hold || ld));
    if (ld) begin
      chk("R7 spec_line", 64'(spec_line), 64'(line));
      m_hold = 1'b1; m_line = line;
      for (int i = 0; i < 8; i++) if (!mpv[i]) begin mpv[i] = 1'b1; mpl[i] = line; break; end
    end
  endtask

  task automatic drain(input int stall);
    if (!m_hold) return;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R8 held valid", 64'(spec_valid), 64'd1);
      chk("R8 held line", 64'(spec_line), 64'(m_line));
    end
    @(negedge clk);
    spec_ready = 1'b1;
    @(negedge clk);
    spec_ready = 1'b0;
    m_hold = 1'b0;
    chk("R8 drop after accept", 64'(spec_valid), 64'd0);
  endtask

  task automatic probe(input logic [LINE_W-1:0] line);
    bit e;
    @(negedge clk);
    miss_valid = 1'b1; miss_line = line;
    e = m_has(line);
    #2;
    chk("R10 merge", 64'(miss_merge), 64'(e));
    chk("R10 fetch", 64'(miss_fetch), 64'(!e));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic do_res(input int id, input bit out);
    int a;
    @(negedge clk);
    res_valid = 1'b1; res_id = 4'(id); res_offchip = out;
    a = (t_sum[id] < 0) ? -t_sum[id] : t_sum[id];
    if (t_done[id] && ((t_dec[id] != out) || a < 4)) begin
      int ix [3];
      ix[0] = t_i0[id]; ix[1] = t_i1[id]; ix[2] = t_i2[id];
      for (int f = 0; f < 3; f++) begin
        if (out && w[f][ix[f]] < 15) w[f][ix[f]]++;
        else if (!out && w[f][ix[f]] > -16) w[f][ix[f]]--;
      end
    end
    t_done[id] = 1'b0;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic do_cmp();
    int j;
    if (m_cnt() == 0) return;
    j = int'($urandom % 8);
    while (!mpv[j]) j = (j + 1) % 8;
    @(negedge clk);
    cmp_valid = 1'b1; cmp_line = mpl[j];
    mpv[j] = 1'b0;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  function automatic logic [LINE_W-1:0] pool_line();
    return LINE_W'(34'h100 + 34'($urandom % 12));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; thr_we = 1'b0; thr_val = '0;
    ld_valid = 1'b0; ld_id = '0; ld_pc = '0;
    adr_valid = 1'b0; adr_id = '0; adr_paddr = '0;
    res_valid = 1'b0; res_id = '0; res_offchip = 1'b0;
    spec_ready = 1'b0; cmp_valid = 1'b0; cmp_line = '0;
    miss_valid = 1'b0; miss_line = '0;
    for (int f = 0; f < 3; f++) for (int e = 0; e < 64; e++) w[f][e] = 0;
    for (int k = 0; k < 4; k++) hist[k] = 0;
    for (int i = 0; i < 16; i++) t_done[i] = 1'b0;
    for (int i = 0; i < 8; i++) mpv[i] = 1'b0;
    thr = 0; m_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pred_valid idle", 64'(pred_valid), 64'd0);
    chk("R1 spec_valid idle", 64'(spec_valid), 64'd0);
    probe(LINE_W'(34'h100));

    for (int it = 0; it < 400; it++) begin
      int ka, kb, ida, idb;
      bit oa, ob;
      logic [LINE_W-1:0] la, lb;
      string tg;
      if (it == 40) set_thr(46);      // above any reachable sum: R11
      if (it == 50) set_thr(-2);
      if (it == 150) set_thr(3);
      if (it >= 250 && it % 50 == 0) set_thr(int'($urandom % 13) - 6);
      ka = int'($urandom % 8); kb = int'($urandom % 8);
      ida = (2 * it) % 16; idb = ida + 1;
      oa = (ka < 4) ? ($urandom % 10 != 0) : ($urandom % 10 == 0);
      ob = (kb < 4) ? ($urandom % 10 != 0) : ($urandom % 10 == 0);
      la = pool_line(); lb = (it % 7 == 0) ? la : pool_line();
      tg = (it >= 40 && it < 50) ? "R11" : ((it % 5 == 1) ? "R6" : "R2/R4/R5");
      do_load(ida, pc_of(ka));
      do_load(idb, pc_of(kb));
      do_addr(idb, lb, tg);
      do_addr(ida, la, tg);
      drain(int'($urandom % 3));
      probe(pool_line());
      if (it % 5 == 0) do_res((ida + 8) % 16, 1'b1);   // idle identifier, R6
      do_res(ida, oa);
      do_res(idb, ob);
      if ($urandom % 3 == 0) do_cmp();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule